// File: doc/BRIEF.md
# Storage Key Protection Checker

This block holds a 7-bit protection key for every 4 KB frame of a small real memory and rules on each memory request presented to it. A request names a frame, says whether it is a store, an operand fetch or an instruction fetch, and carries a 4-bit access key. One cycle later the block raises exactly one of two pulses: a grant, or a protection exception. Granted requests also record use in the frame's key: a reference mark on any access and a change mark on a store.

A separate management port lets a supervisor write a whole key, read a key back, or read and clear a frame's reference mark in one operation. A key write and a request to the same frame in the same cycle are ordered with the write first, so the request is judged against the new key and its marks land on top of it. Read operations return the key as it stood at the start of the cycle.

Top module: `frame_key_guard`

## Requirements
- R1: After a synchronous active-low reset every frame key is 7'h00 and rsp_grant, rsp_prot_exc, mgt_rdone, mgt_rkey and mgt_ref_old are all zero.
- R2: A request whose access key is 4'h0 is granted whatever the frame key holds.
- R3: A store (req_kind 2'd1) is granted only when req_key equals key bits [3:0] of the frame, or is zero; otherwise it raises rsp_prot_exc.
- R4: A fetch (req_kind 2'd0 operand, 2'd2 instruction, 2'd3 treated as operand) from a frame whose key bit 4 is clear is granted with any access key.
- R5: A fetch from a frame whose key bit 4 is set is granted only on a key match or a zero key, identically for operand and instruction fetches.
- R6: Each valid request produces exactly one of rsp_grant or rsp_prot_exc, one cycle later, for one cycle; no request produces neither.
- R7: A granted access sets key bit 5 (reference) of its frame; a granted store also sets key bit 6 (change); a granted fetch leaves bit 6 as it was.
- R8: A denied access leaves the frame key, including bits 5 and 6, unchanged.
- R9: Key bits 5 and 6 take no part in the grant decision.
- R10: mgt_op 2'd2 returns the full frame key on mgt_rkey with mgt_rdone high one cycle later, as it stood before any same-cycle update.
- R11: mgt_op 2'd3 returns the frame's old bit 5 on mgt_ref_old (and the old key on mgt_rkey) one cycle later and clears bit 5, leaving the other bits; a granted access to the same frame in the same cycle sets it again.
- R12: mgt_op 2'd1 writes mgt_wkey as the frame key; a request to that frame in the same cycle is judged against the written key and its marks are applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_frame | input | FRAME_W | Frame number of the request |
| req_kind | input | 2 | 0 operand fetch, 1 store, 2 instruction fetch, 3 operand fetch |
| req_key | input | 4 | Access key carried by the request |
| rsp_grant | output | 1 | Request of the previous cycle granted |
| rsp_prot_exc | output | 1 | Request of the previous cycle denied |
| mgt_op | input | 2 | 0 idle, 1 write key, 2 read key, 3 read and clear reference |
| mgt_frame | input | FRAME_W | Frame addressed by the management operation |
| mgt_wkey | input | 7 | Key written by op 1: [3:0] control, [4] fetch guard, [5] reference, [6] change |
| mgt_rkey | output | 7 | Key returned by op 2 or 3 |
| mgt_ref_old | output | 1 | Reference bit before op 2 or 3 |
| mgt_rdone | output | 1 | mgt_rkey and mgt_ref_old valid |

## Verification
The bench goes after the places where the fetch guard and the store rule part ways: a fetch from an unguarded frame with a wrong key, which a design that applied the store rule to fetches would deny, and an instruction fetch from a guarded frame, which a design that exempted instruction fetches would grant. It checks that a denied request leaves the marks clear, which a design that marked before deciding would break, and that frames preloaded with reference and change set rule identically to clean ones. Same-cycle orderings are probed: a key write plus a store that only the new key admits, a read racing a store that must return the old key, and a reference clear racing a fetch that must leave the mark set. A reset in mid-run followed by a read of every frame catches keys that survive reset.

// File: rtl/fkg_pkg.sv
// Shared encodings for the storage key checker.
// Assumes a 7-bit frame key: [3:0] control, [4] fetch guard, [5] reference, [6] change.
package fkg_pkg;
    localparam int ACC_W   = 4;
    localparam int KEY_W   = 7;
    localparam int GUARD_B = 4;
    localparam int REF_B   = 5;
    localparam int CHG_B   = 6;

    typedef enum logic [1:0] {
        KIND_OPFETCH = 2'd0,
        KIND_STORE   = 2'd1,
        KIND_IFETCH  = 2'd2,
        KIND_OPALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        MGT_IDLE     = 2'd0,
        MGT_SETKEY   = 2'd1,
        MGT_READKEY  = 2'd2,
        MGT_CLEARREF = 2'd3
    } mgt_op_e;
endpackage

// File: rtl/fkg_decide.sv
// Grant rule for one request against one frame key.
// Pure combinational; assumes the caller already applied any same-cycle key write.
module fkg_decide
    import fkg_pkg::*;
(
    input  logic             valid_i,
    input  logic             is_store_i,
    input  logic [ACC_W-1:0] acc_key_i,
    input  logic [KEY_W-1:0] frame_key_i,
    output logic             grant_o,
    output logic             deny_o
);
    logic master;
    logic match;
    logic open_fetch;

    // Evaluate the three ways a request may pass.
    always_comb begin
        master     = (acc_key_i == '0);
        match      = (acc_key_i == frame_key_i[ACC_W-1:0]);
        open_fetch = !is_store_i && !frame_key_i[GUARD_B];
        grant_o    = valid_i && (master || match || open_fetch);
        deny_o     = valid_i && !(master || match || open_fetch);
    end
endmodule

// File: rtl/fkg_key_bank.sv
// Key storage, one register per frame, with write, reference-clear and usage marking.
// Assumes write and reference-clear never occur together (one management port);
// marking is applied after write or clear so a same-cycle access lands on top.
module fkg_key_bank
    import fkg_pkg::*;
#(
    parameter int FRAMES  = 16,
    localparam int FRAME_W = $clog2(FRAMES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en_i,
    input  logic [FRAME_W-1:0]             set_frame_i,
    input  logic [KEY_W-1:0]               set_key_i,
    input  logic                           clr_en_i,
    input  logic [FRAME_W-1:0]             clr_frame_i,
    input  logic                           mark_en_i,
    input  logic [FRAME_W-1:0]             mark_frame_i,
    input  logic                           mark_store_i,
    output logic [FRAMES-1:0][KEY_W-1:0]   keys_o
);
    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        logic [KEY_W-1:0] nxt;

        // Next key: write or clear first, then usage marks.
        always_comb begin
            nxt = keys_o[f];
            if (set_en_i && set_frame_i == FRAME_W'(f)) nxt = set_key_i;
            if (clr_en_i && clr_frame_i == FRAME_W'(f)) nxt[REF_B] = 1'b0;
            if (mark_en_i && mark_frame_i == FRAME_W'(f)) begin
                nxt[REF_B] = 1'b1;
                if (mark_store_i) nxt[CHG_B] = 1'b1;
            end
        end

        // Hold the frame key; zero on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) keys_o[f] <= '0;
            else        keys_o[f] <= nxt;
        end
    end

    assert_mark_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en_i |=> keys_o[$past(mark_frame_i)][REF_B]);
    assert_mark_chg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en_i && mark_store_i) |=> keys_o[$past(mark_frame_i)][CHG_B]);
    assert_clear_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !(mark_en_i && mark_frame_i == clr_frame_i))
            |=> !keys_o[$past(clr_frame_i)][REF_B]);
endmodule

// File: rtl/fkg_readback.sv
// Registers the management read result one cycle after a read or clear operation.
// Assumes key_i is the frame key before any same-cycle update.
module fkg_readback
    import fkg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  logic [KEY_W-1:0] key_i,
    output logic [KEY_W-1:0] rkey_o,
    output logic             ref_old_o,
    output logic             rdone_o
);
    // Capture the key on a read, otherwise return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_en_i) begin
            rkey_o    <= '0;
            ref_old_o <= 1'b0;
            rdone_o   <= 1'b0;
        end else begin
            rkey_o    <= key_i;
            ref_old_o <= key_i[REF_B];
            rdone_o   <= 1'b1;
        end
    end

    assert_ref_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rdone_o |-> (ref_old_o == rkey_o[REF_B]));
endmodule

// File: rtl/frame_key_guard.sv
// Storage key protection checker: judges each request against its frame key,
// marks usage on granted requests and serves key management operations.
// Assumes FRAMES is a power of two; a key write is ordered before a same-cycle request.
module frame_key_guard
    import fkg_pkg::*;
#(
    parameter int FRAMES  = 16,
    localparam int FRAME_W = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [FRAME_W-1:0] req_frame,
    input  logic [1:0]         req_kind,
    input  logic [3:0]         req_key,
    output logic               rsp_grant,
    output logic               rsp_prot_exc,
    input  logic [1:0]         mgt_op,
    input  logic [FRAME_W-1:0] mgt_frame,
    input  logic [6:0]         mgt_wkey,
    output logic [6:0]         mgt_rkey,
    output logic               mgt_ref_old,
    output logic               mgt_rdone
);
    logic [FRAMES-1:0][KEY_W-1:0] keys;
    logic [KEY_W-1:0]             eff_key;
    logic                         is_store;
    logic                         set_en;
    logic                         grant;
    logic                         deny;

    // Decode operation and forward a same-cycle key write to the request.
    always_comb begin
        set_en   = (mgt_op_e'(mgt_op) == MGT_SETKEY);
        is_store = (acc_kind_e'(req_kind) == KIND_STORE);
        eff_key  = (set_en && mgt_frame == req_frame) ? mgt_wkey : keys[req_frame];
    end

    fkg_decide u_decide (
        .valid_i     (req_valid),
        .is_store_i  (is_store),
        .acc_key_i   (req_key),
        .frame_key_i (eff_key),
        .grant_o     (grant),
        .deny_o      (deny)
    );

    fkg_key_bank #(.FRAMES(FRAMES)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_en_i     (set_en),
        .set_frame_i  (mgt_frame),
        .set_key_i    (mgt_wkey),
        .clr_en_i     (mgt_op_e'(mgt_op) == MGT_CLEARREF),
        .clr_frame_i  (mgt_frame),
        .mark_en_i    (grant),
        .mark_frame_i (req_frame),
        .mark_store_i (is_store),
        .keys_o       (keys)
    );

    fkg_readback u_rdback (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (mgt_op_e'(mgt_op) == MGT_READKEY || mgt_op_e'(mgt_op) == MGT_CLEARREF),
        .key_i     (keys[mgt_frame]),
        .rkey_o    (mgt_rkey),
        .ref_old_o (mgt_ref_old),
        .rdone_o   (mgt_rdone)
    );

    // Register the outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_grant    <= 1'b0;
            rsp_prot_exc <= 1'b0;
        end else begin
            rsp_grant    <= grant;
            rsp_prot_exc <= deny;
        end
    end

    assert_zero_key_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_key == 4'h0) |=> rsp_grant);
    assert_store_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_store && req_key != 4'h0 && req_key != eff_key[3:0]) |=> rsp_prot_exc);
    assert_guarded_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_store && eff_key[GUARD_B] && req_key != 4'h0 && req_key != eff_key[3:0])
            |=> rsp_prot_exc);
    assert_single_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_grant && rsp_prot_exc));
    assert_outcome_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_grant || rsp_prot_exc) |-> $past(req_valid));
endmodule

// File: tb/tb_frame_key_guard.sv
`timescale 1ns/1ps
module tb_frame_key_guard;
    typedef struct packed {
        logic [3:0] rq;   // requirement number for messages
        logic [1:0] op;
        logic [3:0] mf;
        logic [6:0] wk;
        logic       rv;
        logic [3:0] rf;
        logic [1:0] rt;
        logic [3:0] rk;
        logic       eg;
        logic       ee;
        logic       erd;
        logic [6:0] erk;
    } vec_t;

    function automatic vec_t v(input int rq, input int op, input int mf, input int wk,
                               input int rv, input int rf, input int rt, input int rk,
                               input int eg, input int ee, input int erd, input int erk);
        vec_t x;
        x.rq = 4'(rq); x.op = 2'(op); x.mf = 4'(mf); x.wk = 7'(wk);
        x.rv = 1'(rv); x.rf = 4'(rf); x.rt = 2'(rt); x.rk = 4'(rk);
        x.eg = 1'(eg); x.ee = 1'(ee); x.erd = 1'(erd); x.erk = 7'(erk);
        return x;
    endfunction

    // op: 0 idle 1 write 2 read 3 clear-ref; kind: 0 opfetch 1 store 2 ifetch
    localparam int NV = 37;
    localparam vec_t TBL [NV] = '{
        v(1, 2,3,0,     0,0,0,0, 0,0,1,'h00), // R1 key zero after reset
        v(12,1,3,'h15,  0,0,0,0, 0,0,0,0),    // R12 write guarded key 5
        v(3, 0,0,0,     1,3,1,5, 1,0,0,0),    // R3 store match
        v(7, 2,3,0,     0,0,0,0, 0,0,1,'h75), // R7 ref and change set
        v(3, 0,0,0,     1,3,1,6, 0,1,0,0),    // R3 store mismatch
        v(5, 0,0,0,     1,3,0,6, 0,1,0,0),    // R5 guarded operand fetch
        v(5, 0,0,0,     1,3,2,6, 0,1,0,0),    // R5 guarded instruction fetch
        v(5, 0,0,0,     1,3,2,5, 1,0,0,0),    // R5 instruction fetch match
        v(2, 0,0,0,     1,3,1,0, 1,0,0,0),    // R2 zero key store
        v(12,1,4,'h02,  0,0,0,0, 0,0,0,0),    // R12 unguarded key 2
        v(4, 0,0,0,     1,4,0,9, 1,0,0,0),    // R4 open operand fetch
        v(4, 0,0,0,     1,4,2,15,1,0,0,0),    // R4 open instruction fetch
        v(7, 2,4,0,     0,0,0,0, 0,0,1,'h22), // R7 fetch leaves change clear
        v(3, 0,0,0,     1,4,1,9, 0,1,0,0),    // R3 store to open frame denied
        v(12,1,5,'h17,  0,0,0,0, 0,0,0,0),    // R12 guarded key 7
        v(8, 0,0,0,     1,5,0,1, 0,1,0,0),    // R8 denied fetch
        v(8, 0,0,0,     1,5,1,1, 0,1,0,0),    // R8 denied store
        v(8, 2,5,0,     0,0,0,0, 0,0,1,'h17), // R8 no marks after denials
        v(11,3,3,0,     0,0,0,0, 0,0,1,'h75), // R11 old ref returned
        v(11,2,3,0,     0,0,0,0, 0,0,1,'h55), // R11 ref cleared, rest kept
        v(11,3,3,0,     0,0,0,0, 0,0,1,'h55), // R11 old ref now zero
        v(12,1,6,'h63,  0,0,0,0, 0,0,0,0),    // R12 key 3 with marks preset
        v(9, 0,0,0,     1,6,0,4, 1,0,0,0),    // R9 marks ignored, fetch
        v(9, 0,0,0,     1,6,1,4, 0,1,0,0),    // R9 marks ignored, store deny
        v(9, 0,0,0,     1,6,1,3, 1,0,0,0),    // R9 marks ignored, store grant
        v(12,1,7,'h03,  0,0,0,0, 0,0,0,0),    // R12 key 3 clean
        v(9, 0,0,0,     1,7,0,4, 1,0,0,0),    // R9 clean frame fetch
        v(9, 0,0,0,     1,7,1,4, 0,1,0,0),    // R9 clean frame store deny
        v(12,1,8,'h1A,  1,8,1,10,1,0,0,0),    // R12 write then store same cycle
        v(12,2,8,0,     0,0,0,0, 0,0,1,'h7A), // R12 marks on new key
        v(10,2,10,0,    1,10,1,0,1,0,1,'h00), // R10 read sees pre-store key
        v(10,2,10,0,    0,0,0,0, 0,0,1,'h60), // R10 store landed
        v(11,3,10,0,    1,10,0,0,1,0,1,'h60), // R11 clear raced by fetch
        v(11,2,10,0,    0,0,0,0, 0,0,1,'h60), // R11 ref set again
        v(6, 0,0,0,     0,0,0,0, 0,0,0,0),    // R6 no request, no pulse
        v(12,1,9,'h1C,  1,9,0,3, 0,1,0,0),    // R12 new guard applies now
        v(8, 2,9,0,     0,0,0,0, 0,0,1,'h1C)  // R8 denied, key untouched
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_frame = '0;
    logic [1:0] req_kind = '0;
    logic [3:0] req_key = '0;
    logic       rsp_grant, rsp_prot_exc;
    logic [1:0] mgt_op = '0;
    logic [3:0] mgt_frame = '0;
    logic [6:0] mgt_wkey = '0;
    logic [6:0] mgt_rkey;
    logic       mgt_ref_old, mgt_rdone;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    frame_key_guard #(.FRAMES(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_frame(req_frame), .req_kind(req_kind), .req_key(req_key),
        .rsp_grant(rsp_grant), .rsp_prot_exc(rsp_prot_exc),
        .mgt_op(mgt_op), .mgt_frame(mgt_frame), .mgt_wkey(mgt_wkey),
        .mgt_rkey(mgt_rkey), .mgt_ref_old(mgt_ref_old), .mgt_rdone(mgt_rdone)
    );

    // Drive one vector at a falling edge, check the result at the next falling edge.
    task automatic run(input vec_t x, input int idx);
        bit bad;
        mgt_op = x.op; mgt_frame = x.mf; mgt_wkey = x.wk;
        req_valid = x.rv; req_frame = x.rf; req_kind = x.rt; req_key = x.rk;
        @(negedge clk);
        n_chk++;
        bad = (rsp_grant !== x.eg) || (rsp_prot_exc !== x.ee) || (mgt_rdone !== x.erd);
        if (x.erd) bad = bad || (mgt_rkey !== x.erk) || (mgt_ref_old !== x.erk[5]);
        if (bad) begin
            n_bad++;
            $display("FAIL R%0d vector %0d: grant=%b exc=%b rdone=%b rkey=%h ref=%b, expected grant=%b exc=%b rdone=%b rkey=%h ref=%b",
                     x.rq, idx, rsp_grant, rsp_prot_exc, mgt_rdone, mgt_rkey, mgt_ref_old,
                     x.eg, x.ee, x.erd, x.erk, x.erk[5]);
        end
    endtask

    task automatic check_quiet(input int idx);
        n_chk++;
        if (rsp_grant !== 1'b0 || rsp_prot_exc !== 1'b0 || mgt_rdone !== 1'b0 || mgt_rkey !== 7'h00) begin
            n_bad++;
            $display("FAIL R1 step %0d: grant=%b exc=%b rdone=%b rkey=%h, expected all zero",
                     idx, rsp_grant, rsp_prot_exc, mgt_rdone, mgt_rkey);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_quiet(0);                               // R1 outputs after reset
        for (int i = 0; i < NV; i++) run(TBL[i], i);
        // Last frame boundary: R3 on frame 15
        run(v(12,1,15,'h1F, 0,0,0,0, 0,0,0,0), 100);
        run(v(3, 0,0,0,     1,15,1,15,1,0,0,0), 101);
        run(v(3, 0,0,0,     1,15,0,14,0,1,0,0), 102);
        // R1 mid-run reset while a request is pending
        req_valid = 1'b1; req_frame = 4'd15; req_key = 4'd0; mgt_op = 2'd2;
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet(200);
        @(negedge clk);
        check_quiet(201);
        rst_n = 1'b1;
        for (int f = 0; f < 16; f++) run(v(1, 2,f,0, 0,0,0,0, 0,0,1,'h00), 300 + f); // R1
        run(v(6, 0,0,0, 0,0,0,0, 0,0,0,0), 400);      // R6 quiet after reads
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule